// File: doc/BRIEF.md
# Multichannel CIC interpolator

The block raises the sample rate of several complex baseband channels by six with a fifth-order cascaded integrator-comb structure. The channels share one clock, which runs at the high rate. Low-rate samples come in time-division order, each tagged with a channel index. One comb datapath serves every channel in turn and keeps five delay words per channel and per rail. Each accepted sample leaves the comb as a single result. That result is injected into a five-stage integrator chain owned by that channel. Every chain advances on every clock and sees zero in the clocks that carry no comb result for it, which is how the zero-stuffing happens.

Each channel should be fed once every six clocks, which gives five zero samples between comb results. At that rate the DC gain is 6^4 = 1296. A fixed rounding shift of 11 bits brings this back near unity, and the result is saturated to 16 bits. Internal words are 29 bits wide and wrap in two's complement. The real and imaginary rails are handled the same way and independently. A synchronous clear input zeroes all delay words, pipeline registers, integrators and outputs in one clock. It serves as the recovery path for corrupted integrator state.

Top module: `cic_interp_mc`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted sample has propagated, every output lane reads 0.
- R2: Each accepted sample is differenced five times against the stored history of its own channel and rail only. Any interleaving order of channels within a frame gives the same per-channel result.
- R3: Every channel's integrator chain advances on every clock. In clocks with no comb result for that channel its input is zero, so one impulse gives the full interpolated response.
- R4: A sample accepted at clock edge t first changes its channel's output at edge t+6. Before that edge the output keeps its old value.
- R5: The output is floor((v + 1024) / 2048) of the last integrator value v. A constant input x, fed every 6 clocks, settles to floor((1296*x + 1024) / 2048).
- R6: Scaled results outside [-32768, 32767] clamp to the nearest limit. A constant 30000 fed every 8 clocks reads 32767, and -30000 reads -32768.
- R7: Samples for one channel never change the output lanes of another channel.
- R8: A sample whose in_ch_i is NUM_CH or larger (3 with the defaults) is discarded and changes no state.
- R9: A clock edge with clr_i high zeroes all internal state, and the sample presented with it is discarded. Outputs read 0 after that edge and stay 0 until a new sample propagates.
- R10: The real and imaginary rails are processed identically and never mix.
- R11: Channel c drives bits [16c+15:16c] of out_re_o and out_im_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all internal registers |
| in_vld_i | input | 1 | Low-rate sample present this clock |
| in_ch_i | input | 2 | Channel index of the presented sample |
| in_re_i | input | 16 | Real part, two's complement |
| in_im_i | input | 16 | Imaginary part, two's complement |
| out_re_o | output | 48 | Real outputs, 16 bits per channel, channel 0 lowest |
| out_im_o | output | 48 | Imaginary outputs, 16 bits per channel, channel 0 lowest |

## Verification
A delay word stored under the wrong channel, or read from the wrong one, shows six clocks after the next sample for that channel. It appears as a lasting offset or oscillation on that channel's lanes, and its neighbour carries the matching error. A broken integrator feedback, or a zero-stuffing path that leaks, shows within a few clocks as drift that never settles. The bench keeps its own model of each channel and compares every output lane on every clock, so such faults are caught at their first visible cycle. Wrong rounding, a wrong shift or a wrong clamp shows up at the settled DC and saturation levels.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int unsigned CIC_IN_W   = 16;
  localparam int unsigned CIC_ORDER  = 5;
  localparam int unsigned CIC_RATE   = 6;
  localparam int unsigned CIC_NUM_CH = 3;

  // bits needed to hold rate**order
  function automatic int unsigned cic_log2_pow(input int unsigned rate, input int unsigned order);
    longint unsigned p;
    int unsigned     b;
    p = 1;
    for (int unsigned i = 0; i < order; i++) p = p * rate;
    b = 0;
    while ((longint'(1) << b) < p) b++;
    return b;
  endfunction
endpackage

// File: rtl/cic_comb_tdm.sv
module cic_comb_tdm #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned ORDER  = 5,
  parameter int unsigned IN_W   = 16,
  parameter int unsigned ACC_W  = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             in_vld_i,
  input  logic [CH_W-1:0]  in_ch_i,
  input  logic [IN_W-1:0]  in_dat_i,
  output logic             comb_vld_o,
  output logic [CH_W-1:0]  comb_ch_o,
  output logic [ACC_W-1:0] comb_dat_o
);
  localparam logic [CH_W:0] CH_LIM = (CH_W+1)'(NUM_CH);

  logic             ch_ok, take;
  logic [CH_W-1:0]  sel_ch;
  logic [ACC_W-1:0] dly_q [NUM_CH][ORDER];
  logic [ACC_W-1:0] stg   [ORDER+1];

  assign ch_ok  = ({1'b0, in_ch_i} < CH_LIM);
  assign take   = in_vld_i & ch_ok;
  assign sel_ch = ch_ok ? in_ch_i : '0;

  always_comb begin
    stg[0] = {{(ACC_W-IN_W){in_dat_i[IN_W-1]}}, in_dat_i};
    for (int k = 0; k < int'(ORDER); k++) stg[k+1] = stg[k] - dly_q[sel_ch][k];
  end

  // per-channel delay words, one per stage input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < int'(NUM_CH); c++)
        for (int k = 0; k < int'(ORDER); k++) dly_q[c][k] <= '0;
    end else if (clr_i) begin
      for (int c = 0; c < int'(NUM_CH); c++)
        for (int k = 0; k < int'(ORDER); k++) dly_q[c][k] <= '0;
    end else if (take) begin
      for (int k = 0; k < int'(ORDER); k++) dly_q[sel_ch][k] <= stg[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comb_vld_o <= 1'b0;
      comb_ch_o  <= '0;
      comb_dat_o <= '0;
    end else if (clr_i) begin
      comb_vld_o <= 1'b0;
      comb_ch_o  <= '0;
      comb_dat_o <= '0;
    end else begin
      comb_vld_o <= take;
      if (take) begin
        comb_ch_o  <= sel_ch;
        comb_dat_o <= stg[ORDER];
      end
    end
  end

  AST_BAD_CH_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_vld_i && !ch_ok) |=> !comb_vld_o); // R8

  AST_COMB_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !comb_vld_o); // R9

  AST_COMB_ISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_vld_i && ch_ok && !clr_i) |=> (comb_vld_o && comb_ch_o == $past(in_ch_i))); // R4
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int unsigned ORDER = 5,
  parameter int unsigned ACC_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] imp_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q [ORDER];
  logic             idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(ORDER); k++) acc_q[k] <= '0;
    end else if (clr_i) begin
      for (int k = 0; k < int'(ORDER); k++) acc_q[k] <= '0;
    end else begin
      acc_q[0] <= acc_q[0] + imp_i;
      for (int k = 1; k < int'(ORDER); k++) acc_q[k] <= acc_q[k] + acc_q[k-1];
    end
  end

  assign acc_o = acc_q[ORDER-1];

  always_comb begin
    idle = 1'b1;
    for (int k = 0; k < int'(ORDER); k++) idle = idle & (acc_q[k] == '0);
  end

  AST_INTEG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && imp_i == '0) |=> idle); // R3
endmodule

// File: rtl/cic_out_scale.sv
module cic_out_scale #(
  parameter int unsigned ACC_W = 29,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned SHIFT = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] dat_o
);
  localparam logic signed [ACC_W:0] RND    = (ACC_W+1)'(1) << (SHIFT-1);
  localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((64'd1 << (OUT_W-1)) - 64'd1);
  localparam logic signed [ACC_W:0] SAT_LO = ~SAT_HI;

  logic signed [ACC_W:0] sum, shd;
  logic [OUT_W-1:0]      nxt;

  always_comb begin
    sum = $signed({acc_i[ACC_W-1], acc_i}) + RND;
    shd = sum >>> SHIFT;
    if (shd > SAT_HI)      nxt = SAT_HI[OUT_W-1:0];
    else if (shd < SAT_LO) nxt = SAT_LO[OUT_W-1:0];
    else                   nxt = shd[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dat_o <= '0;
    else if (clr_i) dat_o <= '0;
    else            dat_o <= nxt;
  end

  AST_OUT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !$past(clr_i) && $stable(acc_i)) |=> $stable(dat_o)); // R5
endmodule

// File: rtl/cic_interp_mc.sv
module cic_interp_mc
  import cic_pkg::*;
#(
  parameter int unsigned NUM_CH = CIC_NUM_CH,
  parameter int unsigned IN_W   = CIC_IN_W,
  parameter int unsigned ORDER  = CIC_ORDER,
  parameter int unsigned RATE   = CIC_RATE,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   in_vld_i,
  input  logic [CH_W-1:0]        in_ch_i,
  input  logic [IN_W-1:0]        in_re_i,
  input  logic [IN_W-1:0]        in_im_i,
  output logic [NUM_CH*IN_W-1:0] out_re_o,
  output logic [NUM_CH*IN_W-1:0] out_im_o
);
  localparam int unsigned ACC_W = IN_W + cic_log2_pow(RATE, ORDER);
  localparam int unsigned SHIFT = cic_log2_pow(RATE, ORDER - 1);

  for (genvar r = 0; r < 2; r++) begin : g_rail
    logic [IN_W-1:0]  dat;
    logic             c_vld;
    logic [CH_W-1:0]  c_ch;
    logic [ACC_W-1:0] c_dat;

    assign dat = (r == 0) ? in_re_i : in_im_i;

    cic_comb_tdm #(
      .NUM_CH(NUM_CH), .CH_W(CH_W), .ORDER(ORDER), .IN_W(IN_W), .ACC_W(ACC_W)
    ) u_comb (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
      .in_vld_i(in_vld_i), .in_ch_i(in_ch_i), .in_dat_i(dat),
      .comb_vld_o(c_vld), .comb_ch_o(c_ch), .comb_dat_o(c_dat)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [ACC_W-1:0] imp, acc;
      logic [IN_W-1:0]  y;

      // zero-stuffing: impulse only in the clock carrying this channel's comb result
      assign imp = (c_vld && c_ch == CH_W'(c)) ? c_dat : '0;

      cic_integ_chain #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .imp_i(imp), .acc_o(acc)
      );

      cic_out_scale #(.ACC_W(ACC_W), .OUT_W(IN_W), .SHIFT(SHIFT)) u_scale (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .acc_i(acc), .dat_o(y)
      );

      if (r == 0) begin : g_re
        assign out_re_o[c*IN_W +: IN_W] = y;
      end else begin : g_im
        assign out_im_o[c*IN_W +: IN_W] = y;
      end
    end
  end

  AST_CLEAR_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i, 2) |-> (out_re_o == '0 && out_im_o == '0)); // R9
endmodule

// File: tb/cic_interp_mc_tb.sv
module cic_interp_mc_tb;
  localparam int TCLK  = 10;
  localparam int NCH   = 3;
  localparam int ORD   = 5;
  localparam int W     = 16;
  localparam int ACCW  = 29;
  localparam int WDOG  = 20000;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, vld = 1'b0;
  logic [1:0]       ch = '0;
  logic [W-1:0]     re = '0, im = '0;
  logic [NCH*W-1:0] out_re, out_im;

  int n_chk = 0, n_err = 0, cyc_cnt = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  string cur_req = "R1";

  cic_interp_mc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .in_vld_i(vld), .in_ch_i(ch),
    .in_re_i(re), .in_im_i(im), .out_re_o(out_re), .out_im_o(out_im)
  );

  always #(TCLK/2) clk = ~clk;

  // ---------------- reference model ----------------
  longint m_dly [2][NCH][ORD];
  longint m_int [2][NCH][ORD];
  longint m_out [2][NCH];
  longint m_cdat [2];
  bit     m_cvld;
  int     m_cch;

  function automatic longint wrapw(input longint v);
    return (v <<< (64 - ACCW)) >>> (64 - ACCW);
  endfunction

  function automatic longint scale(input longint v);
    longint s;
    s = (v + 1024) >>> 11;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic model_clear();
    for (int r = 0; r < 2; r++) begin
      m_cdat[r] = 0;
      for (int c = 0; c < NCH; c++) begin
        m_out[r][c] = 0;
        for (int k = 0; k < ORD; k++) begin m_dly[r][c][k] = 0; m_int[r][c][k] = 0; end
      end
    end
    m_cvld = 0; m_cch = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n || clr) model_clear();
    else begin
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < NCH; c++) begin
          m_out[r][c] = scale(m_int[r][c][ORD-1]);
          for (int k = ORD-1; k > 0; k--) m_int[r][c][k] = wrapw(m_int[r][c][k] + m_int[r][c][k-1]);
          m_int[r][c][0] = wrapw(m_int[r][c][0] + ((m_cvld && m_cch == c) ? m_cdat[r] : 0));
        end
      if (vld && int'(ch) < NCH) begin
        for (int r = 0; r < 2; r++) begin
          longint v, d;
          v = (r == 0) ? longint'($signed(re)) : longint'($signed(im));
          for (int k = 0; k < ORD; k++) begin
            d = wrapw(v - m_dly[r][int'(ch)][k]);
            m_dly[r][int'(ch)][k] = v;
            v = d;
          end
          m_cdat[r] = v;
        end
        m_cvld = 1; m_cch = int'(ch);
      end else m_cvld = 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s t=%0t got=%0d exp=%0d", req, $time, got, exp);
    end
  endtask

  function automatic longint get_out(input int r, input int c);
    return (r == 0) ? longint'($signed(out_re[c*W +: W])) : longint'($signed(out_im[c*W +: W]));
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_en)
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < NCH; c++)
          chk(get_out(r, c) == m_out[r][c], cur_req, get_out(r, c), m_out[r][c]);
  end

  task automatic cyc(input bit v, input int c, input int a, input int b);
    vld = v; ch = c[1:0]; re = a[W-1:0]; im = b[W-1:0];
    @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1; cyc(0, 0, 0, 0); clr = 1'b0;
  endtask

  task automatic expect_all_zero(input string req);
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < NCH; c++) chk(get_out(r, c) == 0, req, get_out(r, c), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WDOG && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired got=%0d exp=%0d", cyc_cnt, WDOG);
      summary();
    end
  end

  initial begin
    int seed;
    repeat (5) @(negedge clk);
    // R1: reset state
    expect_all_zero("R1");
    rst_n = 1'b1;
    @(negedge clk);
    expect_all_zero("R1");
    cmp_en = 1'b1;

    // R4: single sample on ch1, first change six edges after acceptance
    cur_req = "R4";
    cyc(1, 1, 2048, -2048);
    repeat (5) cyc(0, 0, 0, 0);
    chk(get_out(0, 1) == 0, "R4", get_out(0, 1), 0);
    cyc(0, 0, 0, 0);
    chk(get_out(0, 1) == 1,  "R4", get_out(0, 1), 1);
    chk(get_out(1, 1) == -1, "R4", get_out(1, 1), -1);
    chk(get_out(0, 0) == 0, "R7", get_out(0, 0), 0);
    chk(get_out(0, 2) == 0, "R7", get_out(0, 2), 0);
    // R3: rest of impulse response with zero-stuffed integrator inputs
    cur_req = "R3";
    repeat (40) cyc(0, 0, 0, 0);
    chk(get_out(0, 1) != 0, "R3", get_out(0, 1), 1);

    // R9: clear flushes everything
    cur_req = "R9";
    do_clear();
    expect_all_zero("R9");
    repeat (8) cyc(0, 0, 0, 0);
    expect_all_zero("R9");

    // R8: out-of-range channel only
    cur_req = "R8";
    repeat (20) cyc(1, 3, 20000, -20000);
    expect_all_zero("R8");

    // R5 / R10 / R11: DC per channel, frame of 6 clocks, slot 3 out-of-range
    cur_req = "R5";
    for (int f = 0; f < 60; f++) begin
      cyc(1, 0, 1000, -1000);
      cyc(1, 1, 32767, -32768);
      cyc(1, 2, 0, 5);
      cyc(1, 3, 12345, -12345);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
    end
    chk(get_out(0, 0) == 633,    "R5", get_out(0, 0), 633);
    chk(get_out(1, 0) == -633,   "R5", get_out(1, 0), -633);
    chk(get_out(0, 1) == 20735,  "R5", get_out(0, 1), 20735);
    chk(get_out(1, 1) == -20736, "R5", get_out(1, 1), -20736);
    chk(get_out(0, 2) == 0, "R10", get_out(0, 2), 0);
    chk(get_out(1, 2) == 3, "R10", get_out(1, 2), 3);
    chk(out_re[W +: W] == 16'd20735, "R11", longint'(out_re[W +: W]), 20735);

    // R6: saturation with longer spacing on ch2
    cur_req = "R6";
    do_clear();
    for (int f = 0; f < 40; f++) begin
      cyc(1, 2, 30000, -30000);
      repeat (7) cyc(0, 0, 0, 0);
    end
    chk(get_out(0, 2) == 32767,  "R6", get_out(0, 2), 32767);
    chk(get_out(1, 2) == -32768, "R6", get_out(1, 2), -32768);
    chk(get_out(0, 0) == 0, "R7", get_out(0, 0), 0);
    chk(get_out(1, 1) == 0, "R7", get_out(1, 1), 0);

    // R2: varying data, rotating channel order per frame
    cur_req = "R2";
    do_clear();
    seed = 7;
    for (int f = 0; f < 50; f++) begin
      for (int s = 0; s < 3; s++) begin
        int a, b;
        seed = seed * 1103515245 + 12345; a = (seed >>> 8) % 30000;
        seed = seed * 1103515245 + 12345; b = (seed >>> 8) % 30000;
        cyc(1, (f + s) % NCH, a, b);
      end
      repeat (3) cyc(0, 0, 0, 0);
    end

    // R9: clear while a sample is presented, then idle
    cur_req = "R9";
    clr = 1'b1; cyc(1, 0, 9999, 9999); clr = 1'b0;
    expect_all_zero("R9");
    repeat (10) cyc(0, 0, 0, 0);
    expect_all_zero("R9");

    done = 1'b1;
    summary();
  end
endmodule